// File: doc/BRIEF.md
# Left-Aligned / Center-Aligned PWM Channel with Selectable Polarity

This block is one pulse-width modulation channel. An up-counter advances on cycles where the chosen clock-enable strobe is high. The strobe comes from one of four prescaled sources. In left-aligned mode the counter runs from zero up to one less than the period value and then wraps, so the output repeats once every `period` strobes. In center-aligned mode the counter climbs and then descends, so one output cycle spans twice the period value.

The duty value is compared against the counter. The polarity input decides which phase the duty value measures. With polarity 1, the output is high for the first `duty` counts. With polarity 0, the output is low for the first `duty` counts and high for the rest. For example, period 4, duty 1 and polarity 0 give a 75% high time at one quarter of the strobe rate.

Period and duty are double-buffered. New values are taken only at the end of a period, or at any time while the channel is off. The alignment mode is captured only while the channel is off, so it cannot change mid-waveform.

Top module: `pwm_chan`

## Requirements
- R1: After reset the channel is idle. `pwm_o` equals the inverse of `pol_i`, and `center_o` is 0.
- R2: The counter advances only on cycles where `tick_i[src_i]` is 1. The `src_i` encoding is 0 = source A, 1 = source B, 2 = scaled A, 3 = scaled B.
- R3: In left-aligned mode the counter steps 0, 1, ... period-1 and then returns to 0, so the output repeats every `period` strobes.
- R4: With `pol_i`=1, `pwm_o` is high while the counter is below the duty value and low otherwise, giving duty/period high time.
- R5: With `pol_i`=0, `pwm_o` is low while the counter is below the duty value and high otherwise, giving (period-duty)/period high time. Period 4, duty 1 gives 6 high cycles out of 8 with a strobe every cycle.
- R6: A period of 0 holds `pwm_o` at the inactive level (`~pol_i`). A duty at or above the period holds `pwm_o` at the active level (`pol_i`) for the whole period.
- R7: `per_i` and `dty_i` take effect at the clock edge that ends a period, or at every edge where `en_i` is 0. At all other edges they are ignored.
- R8: `mode_i` (1 = center-aligned) is captured into `center_o` only at edges where `en_i` is 0. Changes while enabled have no effect on `center_o` or on the waveform.
- R9: In center-aligned mode the counter steps 0 up to period-1, repeats that value, then steps down to 0 and repeats 0. One period is 2*period strobes, and the output is active while the counter is below the duty value.
- R10: At an edge with `en_i`=0 the counter clears, and the output is inactive while the channel is off. At the first edge with `en_i`=1 the channel starts at count 0, and counting begins at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 4 | Clock-enable strobes from the four prescaled sources |
| src_i | input | 2 | Source select for the channel strobe |
| en_i | input | 1 | Channel enable |
| pol_i | input | 1 | Polarity: 1 = duty sets high time, 0 = duty sets low time |
| mode_i | input | 1 | Requested alignment, 1 = center-aligned |
| per_i | input | 8 | Period value (buffered) |
| dty_i | input | 8 | Duty value (buffered) |
| pwm_o | output | 1 | PWM waveform |
| center_o | output | 1 | Alignment mode in force |

## Verification
The assertions assume that `en_i`, `mode_i`, `per_i` and `dty_i` are steady around each rising edge. They also assume that a period value written while running is applied only at a wrap, so the counter never exceeds the period in force. The stimulus changes every input at the falling edge. It draws periods of 0 to 12 and duties of 0 to 14, so both the zero-period case and the duty-above-period case occur often. Mode and polarity flips are mixed into enabled stretches so that the lock on the mode is exercised.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
   localparam int unsigned NUM_SRC = 4;
   localparam int unsigned SRC_W   = $clog2(NUM_SRC);

   typedef enum logic [SRC_W-1:0] {
      SRC_A  = 2'd0,
      SRC_B  = 2'd1,
      SRC_SA = 2'd2,
      SRC_SB = 2'd3
   } pwm_src_e;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } cnt_dir_e;
endpackage

// File: rtl/pwm_clk_sel.sv
module pwm_clk_sel
   import pwm_chan_pkg::*;
(
   input  logic [NUM_SRC-1:0] tick_i,
   input  logic [SRC_W-1:0]   src_i,
   output logic               tick_o
);
   logic [NUM_SRC-1:0] hit;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      assign hit[g] = tick_i[g] && (src_i == SRC_W'(g));
   end

   assign tick_o = |hit;
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
   parameter int unsigned CNT_W     = 8,
   parameter bit          CENTER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             wrap_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic [CNT_W-1:0] dty_i,
   input  logic             mode_i,
   output logic [CNT_W-1:0] per_o,
   output logic [CNT_W-1:0] dty_o,
   output logic             center_o
);
   logic load;
   assign load = !en_i || wrap_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_o <= '0;
         dty_o <= '0;
      end else if (load) begin
         per_o <= per_i;
         dty_o <= dty_i;
      end
   end

   if (CENTER_EN) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     center_o <= 1'b0;
         else if (!en_i) center_o <= mode_i;
      end
   end else begin : g_left_only
      assign center_o = 1'b0;
   end
endmodule

// File: rtl/pwm_cnt.sv
module pwm_cnt
   import pwm_chan_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic             center_i,
   input  logic [CNT_W-1:0] per_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   cnt_dir_e         dir;
   logic             step;
   logic             at_top;
   logic             at_end;
   logic [CNT_W-1:0] top;

   assign top    = per_i - ONE;
   assign step   = en_i && run_i && tick_i;
   assign at_top = (cnt_o == top);
   assign at_end = (per_i == '0) ||
                   (center_i ? (dir == DIR_DOWN && cnt_o == '0) : at_top);
   assign wrap_o = step && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
         dir   <= DIR_UP;
      end else if (!en_i) begin
         cnt_o <= '0;
         dir   <= DIR_UP;
      end else if (step) begin
         if (wrap_o) begin
            cnt_o <= '0;
            dir   <= DIR_UP;
         end else if (!center_i) begin
            cnt_o <= cnt_o + ONE;
         end else if (dir == DIR_UP) begin
            if (at_top) dir   <= DIR_DOWN;
            else        cnt_o <= cnt_o + ONE;
         end else begin
            cnt_o <= cnt_o - ONE;
         end
      end
   end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_chan_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter bit          CENTER_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] tick_i,
   input  logic [SRC_W-1:0]   src_i,
   input  logic               en_i,
   input  logic               pol_i,
   input  logic               mode_i,
   input  logic [CNT_W-1:0]   per_i,
   input  logic [CNT_W-1:0]   dty_i,
   output logic               pwm_o,
   output logic               center_o
);
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("pwm_chan: CNT_W must lie in 2..16");
   end

   logic             tick;
   logic             run_q;
   logic             wrap;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] act_per;
   logic [CNT_W-1:0] act_dty;
   logic             active;

   pwm_clk_sel u_sel (
      .tick_i (tick_i),
      .src_i  (src_i),
      .tick_o (tick)
   );

   pwm_shadow #(.CNT_W(CNT_W), .CENTER_EN(CENTER_EN)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_i),
      .wrap_i   (wrap),
      .per_i    (per_i),
      .dty_i    (dty_i),
      .mode_i   (mode_i),
      .per_o    (act_per),
      .dty_o    (act_dty),
      .center_o (center_o)
   );

   pwm_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_i),
      .run_i    (run_q),
      .tick_i   (tick),
      .center_i (center_o),
      .per_i    (act_per),
      .cnt_o    (cnt),
      .wrap_o   (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= en_i;
   end

   assign active = run_q && (act_per != '0) && (cnt < act_dty);
   assign pwm_o  = active ? pol_i : ~pol_i;
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_i,
   input logic             pol_i,
   input logic             pwm_o,
   input logic             center_o,
   input logic             run_q,
   input logic             wrap,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] act_per
);
   // R10: output is idle one cycle after the enable was low
   p_idle_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_i) |-> (pwm_o == ~pol_i));

   // R8: mode in force is frozen across an enabled edge
   p_mode_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_i) |-> $stable(center_o));

   // R3: counter never passes the period in force
   p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && act_per != '0) |-> (cnt < act_per));

   // R7: buffered period moves only at a wrap while running
   p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !$past(wrap)) |-> $stable(act_per));

   // R6: zero period yields the idle level
   p_zero_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_per == '0) |-> (pwm_o == ~pol_i));
endmodule

bind pwm_chan pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_i     (en_i),
   .pol_i    (pol_i),
   .pwm_o    (pwm_o),
   .center_o (center_o),
   .run_q    (run_q),
   .wrap     (wrap),
   .cnt      (cnt),
   .act_per  (act_per)
);

// File: tb/sim_pwm_chan.sv
module sim_pwm_chan;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] tick_i;
   logic [1:0] src_i;
   logic       en_i, pol_i, mode_i;
   logic [7:0] per_i, dty_i;
   logic       pwm_o, center_o;

   int unsigned n_vec  = 0;
   int unsigned n_fail = 0;

   // bench-side model state
   bit       m_run, m_dir, m_ctr;
   bit [7:0] m_cnt, m_per, m_dty;

   always #2 clk = ~clk;

   pwm_chan u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .src_i(src_i),
      .en_i(en_i), .pol_i(pol_i), .mode_i(mode_i),
      .per_i(per_i), .dty_i(dty_i), .pwm_o(pwm_o), .center_o(center_o)
   );

   function automatic bit exp_pwm();
      if (!m_run || m_per == 0) return ~pol_i;       // R6 R10
      return (m_cnt < m_dty) ? pol_i : ~pol_i;       // R4 R5 R9
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   task automatic model_step();
      bit tk = tick_i[src_i];                         // R2
      if (!en_i) begin                                // R7 R8 R10
         m_run = 0; m_cnt = 0; m_dir = 0;
         m_per = per_i; m_dty = dty_i; m_ctr = mode_i;
      end else begin
         if (m_run && tk) begin
            if (m_per == 0) begin
               m_per = per_i; m_dty = dty_i; m_cnt = 0; m_dir = 0;
            end else if (!m_ctr) begin                // R3
               if (m_cnt == m_per - 1) begin
                  m_cnt = 0; m_per = per_i; m_dty = dty_i;
               end else m_cnt++;
            end else if (!m_dir) begin                // R9
               if (m_cnt == m_per - 1) m_dir = 1; else m_cnt++;
            end else begin
               if (m_cnt == 0) begin
                  m_dir = 0; m_per = per_i; m_dty = dty_i;
               end else m_cnt--;
            end
         end
         m_run = 1;
      end
   endtask

   // one edge: update model, pass the edge, check at the falling edge
   task automatic cycle(output bit hi);
      model_step();
      @(posedge clk);
      @(negedge clk);
      check("R4/R5/R9 pwm", pwm_o, exp_pwm());
      check("R8 center", center_o, m_ctr);
      hi = pwm_o;
   endtask

   task automatic run_count(input int n, output int highs);
      bit h;
      highs = 0;
      for (int i = 0; i < n; i++) begin
         cycle(h);
         highs += h;
      end
   endtask

   task automatic setup(input bit p, input bit md, input int pr, input int dt);
      bit h;
      en_i = 0; pol_i = p; mode_i = md; per_i = 8'(pr); dty_i = 8'(dt);
      tick_i = 4'hF; src_i = 2'd0;
      cycle(h);
      en_i = 1;
      cycle(h);                                       // R10 start edge
   endtask

   initial begin
      int hc;
      bit h;
      void'($urandom(32'd1234));
      rst_n = 0; tick_i = 0; src_i = 0; en_i = 0; pol_i = 1; mode_i = 0;
      per_i = 0; dty_i = 0;
      m_run = 0; m_cnt = 0; m_dir = 0; m_per = 0; m_dty = 0; m_ctr = 0;
      repeat (3) @(negedge clk);
      check("R1 pwm idle", pwm_o, 0);
      check("R1 center", center_o, 0);
      rst_n = 1;

      // directed corners
      setup(0, 0, 4, 1); run_count(8, hc);
      check("R5 high count p4 d1", hc, 6);
      setup(1, 0, 5, 2); run_count(10, hc);
      check("R4 high count p5 d2", hc, 4);
      setup(1, 0, 0, 3); run_count(8, hc);
      check("R6 zero period", hc, 0);
      setup(1, 0, 4, 9); run_count(8, hc);
      check("R6 duty above period", hc, 8);
      setup(1, 1, 3, 1); run_count(12, hc);
      check("R9 center high count", hc, 4);
      // R8: mode flip while running is ignored
      mode_i = 0; run_count(6, hc);
      check("R8 mode held", center_o, 1);
      // R2: strobe only on unselected source -> counter frozen
      setup(1, 0, 4, 1); src_i = 2'd2; tick_i = 4'b1011; run_count(6, hc);
      check("R2 frozen output", hc, 6);
      // R7: new period written mid-run waits for the wrap
      setup(1, 0, 4, 2); per_i = 8'd8; dty_i = 8'd8; run_count(3, hc);
      check("R7 old duty kept", hc, 1);

      // constrained random
      for (int s = 0; s < 300; s++) begin
         pol_i = 1'($urandom); src_i = 2'($urandom);
         for (int c = 0; c < 40; c++) begin
            int dens = $urandom_range(0, 3);
            for (int b = 0; b < 4; b++) tick_i[b] = ($urandom_range(0, 3) <= dens);
            en_i = ($urandom_range(0, 15) != 0);
            if ($urandom_range(0, 7) == 0) mode_i = ~mode_i;
            if ($urandom_range(0, 3) == 0) per_i = 8'($urandom_range(0, 12));
            if ($urandom_range(0, 3) == 0) dty_i = 8'($urandom_range(0, 14));
            cycle(h);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule